// File: doc/BRIEF.md
# Interval-Aging Victim Selector

This block helps a frame-replacement engine decide which of a fixed set of frame slots to give up next. Every slot carries a reference flag and a small saturating counter that measures how many whole intervals have passed since the slot was last touched. A reference strobe marks one slot as used. A periodic tick, produced by a timer outside the block, ages every slot that stayed untouched during the interval and restarts the count of every slot that was touched. After each tick the flags are cleared for the next interval.

On request, the block compares the counters of all slots flagged as valid and returns the index of the valid slot that has been idle longest. The answer is registered and appears one clock after the request. It stays unchanged until the next request. If two or more valid slots share the largest count, the lowest index is returned. If no slot is valid, the block reports that it has no candidate.

Top module: `idle_victim_sel`

## Requirements
- R1: After a synchronous active-low reset, every counter and every reference flag is zero. `vict_idx` reads 0 and `vict_valid` reads 0.
- R2: A cycle with `ref_strobe` high sets the reference flag of slot `ref_slot`. A later tick then clears that slot's counter.
- R3: Counters change only in cycles where `tick` is high. A reference strobe without a tick leaves every counter unchanged.
- R4: On a tick, every slot whose reference flag was 0 has its counter increased by one.
- R5: On a tick, every slot whose reference flag was 1 has its counter set to zero.
- R6: After a tick, every reference flag reads 0, except the flag of a slot referenced in that same cycle.
- R7: When a reference and a tick fall in the same cycle, the tick acts on the flag value held before that cycle. The referenced slot's flag is set afterwards.
- R8: A counter at its maximum value, 2^CNT_W-1 (15 by default), stays there on further unreferenced ticks and does not wrap.
- R9: A request (`vict_req` high) in cycle n places its result on `vict_idx`/`vict_valid` after the clock edge that ends cycle n. The result uses the counters as they stood in cycle n. Without a request, both outputs hold their value.
- R10: When several valid slots share the largest counter value, the lowest-indexed of them is returned.
- R11: Bit i of `slot_valid` marks slot i as a candidate. A slot with its bit at 0 is never returned. When no bit is set, the result is `vict_valid` = 0 and `vict_idx` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_strobe | input | 1 | Marks slot `ref_slot` as referenced this cycle |
| ref_slot | input | IDX_W | Index of the referenced slot |
| tick | input | 1 | End of one aging interval |
| slot_valid | input | N_SLOTS | Per-slot candidate mask, bit i for slot i |
| vict_req | input | 1 | Request a victim choice |
| vict_idx | output | IDX_W | Registered index of the chosen slot |
| vict_valid | output | 1 | Registered flag: a valid candidate was found |

## Verification
The hardest condition to reach from the ports is a counter pinned at saturation while a neighbour sits just below it. Only a long run of ticks with a chosen pattern of references gets the counters there. Without saturation the same run would wrap one counter back to a small value and change the winner. The bench also pairs a tick with a same-cycle reference and then places a request immediately after. This separates using the old flag from using the new one. A second tick that follows shows that the flag survived. A third scenario saturates two counters, one of which was once referenced. A flag that failed to clear would then keep that counter at zero and change the tie result.

// File: rtl/aging_pkg.sv
// Package: shared defaults and the per-slot tick action encoding.
// Assumes: consumers size their own vectors from N_SLOTS and CNT_W.
package aging_pkg;

    parameter int unsigned AGE_SLOTS_DEF = 8;
    parameter int unsigned AGE_CNTW_DEF  = 4;

    // What a slot counter does in the current cycle
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_INC   = 2'd1,
        ACT_CLEAR = 2'd2,
        ACT_SAT   = 2'd3
    } age_act_e;

endpackage

// File: rtl/age_slot.sv
// Module: age_slot
// One tracked slot: a reference flag plus a saturating idle-interval
// counter. On a tick the counter is cleared if the flag was set, or
// incremented (saturating) if it was clear. The flag then takes the
// value of the same-cycle reference.
// Assumes: hit and tick are synchronous single-cycle strobes.
module age_slot
    import aging_pkg::*;
#(
    parameter int unsigned CNT_W = AGE_CNTW_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic             tick,
    output logic             ref_bit,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic             ref_q;
    age_act_e         act;

    // Decide the counter action from the tick and the held flag
    always_comb begin
        act = ACT_HOLD;
        if (tick) begin
            if (ref_q)               act = ACT_CLEAR;
            else if (cnt_q == MAXV)  act = ACT_SAT;
            else                     act = ACT_INC;
        end
    end

    // Counter and reference flag registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ref_q <= 1'b0;
        end else begin
            case (act)
                ACT_INC:   cnt_q <= cnt_q + 1'b1;
                ACT_CLEAR: cnt_q <= '0;
                default:   cnt_q <= cnt_q;
            endcase
            if (tick)     ref_q <= hit;
            else if (hit) ref_q <= 1'b1;
        end
    end

    assign cnt     = cnt_q;
    assign ref_bit = ref_q;

    AST_CLEAR_ON_USE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && ref_q) |=> (cnt_q == '0)); // R5
    AST_AGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ref_q && cnt_q != MAXV) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R4
    AST_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ref_q && cnt_q == MAXV) |=> (cnt_q == MAXV)); // R8
    AST_STILL_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt_q)); // R3
    AST_REF_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> ref_q); // R7
    AST_REF_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !hit) |=> !ref_q); // R6

endmodule

// File: rtl/age_argmax.sv
// Module: age_argmax
// Combinational search for the valid slot with the largest counter.
// A strictly-greater compare in ascending index order makes the lowest
// index win among equal counters.
// Assumes: cnt_flat packs slot i at bits [i*CNT_W +: CNT_W].
module age_argmax #(
    parameter int unsigned N_SLOTS = 8,
    parameter int unsigned CNT_W   = 4,
    parameter int unsigned IDX_W   = 3
) (
    input  logic [N_SLOTS*CNT_W-1:0] cnt_flat,
    input  logic [N_SLOTS-1:0]       valid,
    output logic [IDX_W-1:0]         best_idx,
    output logic                     any_valid
);

    logic [CNT_W-1:0] best_cnt;

    // Linear scan keeping the running winner
    always_comb begin
        best_idx  = '0;
        best_cnt  = '0;
        any_valid = 1'b0;
        for (int i = 0; i < N_SLOTS; i++) begin
            if (valid[i] && (!any_valid || cnt_flat[i*CNT_W +: CNT_W] > best_cnt)) begin
                best_idx  = IDX_W'(i);
                best_cnt  = cnt_flat[i*CNT_W +: CNT_W];
                any_valid = 1'b1;
            end
        end
    end

endmodule

// File: rtl/age_result_reg.sv
// Module: age_result_reg
// Captures the search result on a request and holds it otherwise.
// Assumes: idx_in is 0 whenever any_in is 0.
module age_result_reg #(
    parameter int unsigned IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [IDX_W-1:0] idx_in,
    input  logic             any_in,
    output logic [IDX_W-1:0] idx_q,
    output logic             vld_q
);

    // Load the result on request, hold it otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            vld_q <= 1'b0;
        end else if (req) begin
            idx_q <= idx_in;
            vld_q <= any_in;
        end
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> ($stable(idx_q) && $stable(vld_q))); // R9

endmodule

// File: rtl/idle_victim_sel.sv
// Module: idle_victim_sel (top)
// Tracks idle intervals for N_SLOTS frame slots and nominates the valid
// slot idle longest. Reference decode, per-slot trackers, the search
// and the result register are split into separate pieces.
// Assumes: ref_slot < N_SLOTS when ref_strobe is high; tick comes from
// an external interval timer.
module idle_victim_sel
    import aging_pkg::*;
#(
    parameter int unsigned N_SLOTS = AGE_SLOTS_DEF,
    parameter int unsigned CNT_W   = AGE_CNTW_DEF,
    parameter int unsigned IDX_W   = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ref_strobe,
    input  logic [IDX_W-1:0]   ref_slot,
    input  logic               tick,
    input  logic [N_SLOTS-1:0] slot_valid,
    input  logic               vict_req,
    output logic [IDX_W-1:0]   vict_idx,
    output logic               vict_valid
);

    localparam int unsigned FLAT_W = N_SLOTS * CNT_W;

    logic [N_SLOTS-1:0] hit;
    logic [N_SLOTS-1:0] ref_bits;
    logic [FLAT_W-1:0]  cnt_flat;
    logic [IDX_W-1:0]   pick_idx;
    logic               pick_any;

    // One tracker per slot, each with its own reference decode
    for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
        assign hit[g] = ref_strobe && (ref_slot == IDX_W'(g));

        age_slot #(.CNT_W(CNT_W)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .hit     (hit[g]),
            .tick    (tick),
            .ref_bit (ref_bits[g]),
            .cnt     (cnt_flat[g*CNT_W +: CNT_W])
        );
    end

    age_argmax #(.N_SLOTS(N_SLOTS), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_search (
        .cnt_flat  (cnt_flat),
        .valid     (slot_valid),
        .best_idx  (pick_idx),
        .any_valid (pick_any)
    );

    age_result_reg #(.IDX_W(IDX_W)) u_result (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (vict_req),
        .idx_in (pick_idx),
        .any_in (pick_any),
        .idx_q  (vict_idx),
        .vld_q  (vict_valid)
    );

    AST_EMPTY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (vict_req && slot_valid == '0) |=> (!vict_valid && vict_idx == '0)); // R11
    AST_FOUND_WHEN_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (vict_req && slot_valid != '0) |=> vict_valid); // R9
    AST_SINGLE_REF: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit)); // R2

endmodule

// File: tb/sim_idle_victim_sel.sv
// Bench for idle_victim_sel: a stimulus table walked by one loop, then
// directed scenarios. A behavioural model built from the requirements
// supplies expected results.
module sim_idle_victim_sel;

    localparam int NS   = 8;
    localparam int CW   = 4;
    localparam int IW   = 3;
    localparam int MAXC = 15;
    localparam int NVEC = 16;

    // Vector layout: [13] ref, [12:10] slot, [9] tick, [8] req, [7:0] mask
    localparam logic [13:0] VEC [NVEC] = '{
        {1'b1, 3'd2, 1'b0, 1'b0, 8'hFF},
        {1'b1, 3'd5, 1'b1, 1'b1, 8'hFF},
        {1'b0, 3'd0, 1'b1, 1'b1, 8'hFF},
        {1'b1, 3'd0, 1'b0, 1'b1, 8'h0F},
        {1'b0, 3'd0, 1'b1, 1'b0, 8'hFF},
        {1'b1, 3'd7, 1'b1, 1'b1, 8'hF0},
        {1'b0, 3'd0, 1'b0, 1'b1, 8'h81},
        {1'b1, 3'd3, 1'b0, 1'b0, 8'hFF},
        {1'b1, 3'd1, 1'b1, 1'b1, 8'hFF},
        {1'b0, 3'd0, 1'b1, 1'b1, 8'h0A},
        {1'b0, 3'd0, 1'b0, 1'b1, 8'h00},
        {1'b1, 3'd6, 1'b1, 1'b0, 8'hFF},
        {1'b0, 3'd0, 1'b1, 1'b1, 8'h60},
        {1'b1, 3'd4, 1'b0, 1'b1, 8'h30},
        {1'b0, 3'd0, 1'b1, 1'b1, 8'hFF},
        {1'b0, 3'd0, 1'b0, 1'b1, 8'hC0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ref_strobe = 1'b0;
    logic [IW-1:0] ref_slot = '0;
    logic          tick = 1'b0;
    logic [NS-1:0] slot_valid = '0;
    logic          vict_req = 1'b0;
    logic [IW-1:0] vict_idx;
    logic          vict_valid;

    int n_checks = 0;
    int n_fails  = 0;
    int mcnt [NS];
    bit mref [NS];
    int e_idx = 0;
    bit e_vld = 1'b0;

    always #10 clk = ~clk;

    idle_victim_sel u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_strobe (ref_strobe),
        .ref_slot   (ref_slot),
        .tick       (tick),
        .slot_valid (slot_valid),
        .vict_req   (vict_req),
        .vict_idx   (vict_idx),
        .vict_valid (vict_valid)
    );

    task automatic check(input string tag, input int act_i, input int exp_i,
                         input bit act_v, input bit exp_v);
        n_checks++;
        if (act_i != exp_i || act_v != exp_v) begin
            n_fails++;
            $display("FAIL %s: idx=%0d valid=%0d expected idx=%0d valid=%0d",
                     tag, act_i, act_v, exp_i, exp_v);
        end
    endtask

    // Model choice from the requirements: largest count, lowest index, valid only
    task automatic model_pick(input logic [NS-1:0] mk, output int idx, output bit vld);
        int best;
        idx = 0; vld = 1'b0; best = 0;
        for (int i = 0; i < NS; i++) begin
            if (mk[i] && (!vld || mcnt[i] > best)) begin
                idx = i; best = mcnt[i]; vld = 1'b1;
            end
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < NS; i++) begin
            mcnt[i] = 0; mref[i] = 1'b0;
        end
        e_idx = 0; e_vld = 1'b0;
    endtask

    // One clock: drive, update the model, check outputs 2 ns after the edge
    task automatic step(input bit re, input int rs, input bit tk,
                        input logic [NS-1:0] mk, input bit rq, input string tag);
        int pi;
        bit pv;
        ref_strobe = re; ref_slot = IW'(rs); tick = tk;
        slot_valid = mk; vict_req = rq;
        if (rq) begin
            model_pick(mk, pi, pv);
            e_idx = pi; e_vld = pv;
        end
        @(posedge clk);
        if (tk) begin
            for (int i = 0; i < NS; i++) begin
                if (mref[i]) mcnt[i] = 0;
                else if (mcnt[i] < MAXC) mcnt[i] = mcnt[i] + 1;
                mref[i] = re && (rs == i);
            end
        end else if (re) begin
            mref[rs] = 1'b1;
        end
        #2;
        check(tag, int'(vict_idx), e_idx, vict_valid, e_vld);
    endtask

    task automatic do_reset();
        ref_strobe = 1'b0; tick = 1'b0; vict_req = 1'b0; slot_valid = '0;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #2;
        rst_n = 1'b1;
        model_clear();
    endtask

    initial begin
        #(20 * 150000);
        n_fails++;
        $display("FAIL watchdog: run did not end");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        do_reset();
        // R1: reset state of the outputs
        check("R1 reset outputs", int'(vict_idx), 0, vict_valid, 1'b0);
        // R1/R10: all counters zero after reset, so slot 0 wins
        step(0, 0, 0, 8'hFF, 1, "R1 counters zero");
        step(0, 0, 0, 8'hFC, 1, "R10 tie at zero");

        // Table walk
        for (int v = 0; v < NVEC; v++) begin
            step(VEC[v][13], int'(VEC[v][12:10]), VEC[v][9], VEC[v][7:0], VEC[v][8], "R9 table");
        end

        // R2: a reference marks slot 3, so a tick keeps it at 0 and slot 4 wins
        do_reset();
        step(1, 3, 0, 8'h18, 0, "R2 ref");
        step(0, 0, 1, 8'h18, 0, "R2 tick");
        step(0, 0, 0, 8'h18, 1, "R2 victim 4");
        check("R2 expect slot 4", int'(vict_idx), 4, vict_valid, 1'b1);
        // R3: references without ticks leave counters alone
        for (int k = 0; k < 5; k++) step(1, 4, 0, 8'h18, 0, "R3 hold");
        step(0, 0, 0, 8'h18, 1, "R3 unchanged");
        check("R3 expect slot 4", int'(vict_idx), 4, vict_valid, 1'b1);

        // R4: unreferenced slot 7 ages while the others are touched
        do_reset();
        for (int k = 0; k < 7; k++) step(1, k, 0, 8'hFF, 0, "R4 refs");
        step(0, 0, 1, 8'hFF, 0, "R4 tick");
        step(0, 0, 0, 8'hFF, 1, "R4 victim 7");
        check("R4 expect slot 7", int'(vict_idx), 7, vict_valid, 1'b1);
        // R11: the oldest slot masked out is never returned
        step(0, 0, 0, 8'h7F, 1, "R11 masked");
        check("R11 expect slot 0", int'(vict_idx), 0, vict_valid, 1'b1);
        step(0, 0, 0, 8'h00, 1, "R11 empty mask");
        check("R11 expect none", int'(vict_idx), 0, vict_valid, 1'b0);
        // R9: outputs hold while no request arrives
        step(0, 0, 1, 8'hFF, 0, "R9 hold over tick");
        step(1, 2, 0, 8'hFF, 0, "R9 hold over ref");

        // R5: a referenced slot restarts from zero on the tick
        do_reset();
        step(0, 0, 1, 8'h03, 0, "R5 tick1");
        step(1, 0, 0, 8'h03, 0, "R5 ref");
        step(0, 0, 1, 8'h03, 0, "R5 tick2");
        step(0, 0, 0, 8'h03, 1, "R5 victim 1");
        check("R5 expect slot 1", int'(vict_idx), 1, vict_valid, 1'b1);

        // R7: same-cycle reference and tick use the old flag
        do_reset();
        step(1, 0, 1, 8'hFF, 0, "R7 ref+tick");
        step(0, 0, 0, 8'hFF, 1, "R7 old flag");
        check("R7 all equal, slot 0", int'(vict_idx), 0, vict_valid, 1'b1);
        step(0, 0, 1, 8'hFF, 0, "R7 tick");
        step(0, 0, 0, 8'hFF, 1, "R7 flag kept");
        check("R7 slot 0 cleared, slot 1", int'(vict_idx), 1, vict_valid, 1'b1);

        // R6: flags clear after a tick; both counters saturate, tie to slot 0
        do_reset();
        step(1, 0, 0, 8'h03, 0, "R6 ref");
        for (int k = 0; k < 20; k++) step(0, 0, 1, 8'h03, 0, "R6 ticks");
        step(0, 0, 0, 8'h03, 1, "R6 flags cleared");
        check("R6 expect slot 0", int'(vict_idx), 0, vict_valid, 1'b1);

        // R8: slot 2 saturates at 15 while slot 5 reaches 14
        do_reset();
        step(1, 5, 1, 8'h24, 0, "R8 first tick");
        for (int k = 0; k < 15; k++) step(0, 0, 1, 8'h24, 0, "R8 ticks");
        step(0, 0, 0, 8'h24, 1, "R8 saturated");
        check("R8 expect slot 2", int'(vict_idx), 2, vict_valid, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule